// File: doc/BRIEF.md
# Multicycle Five-Step RISC Core

This block is a compact 32-bit load-store processor that executes one instruction at a time. Each instruction walks through five clock cycles: fetch, decode with register read, execute, memory access and write-back. Values that cross from one step to the next are held in dedicated latches: instruction word, next-PC, two operands, extended immediate, ALU result, zero flag and loaded word. Instruction memory and data memory are separate ports, and both are read combinationally by the surrounding system.

The core handles register-register ADD, SUB and signed SLT, word load and store with base-plus-displacement addressing, branch-if-zero, an unconditional PC-relative jump and a halt instruction. Once halt has been decoded, the core freezes its program counter and raises `halted` until the next reset. It is meant to be dropped next to small instruction and data memories in a controller or test environment.

Top module: `mc_risc_core`

## Requirements
- R1: While `rst_n` is low, the PC and all 32 registers are cleared, `imem_addr` reads 0, `halted` is low and `dmem_we` is low.
- R2: Every non-halt instruction takes exactly five cycles. `imem_addr` carries the instruction's PC in its first cycle, and the next instruction is fetched from the updated PC five cycles later.
- R3: Register-register format is opcode 0x00 in bits 31..26, rs1 in 25..21, rs2 in 20..16, rd in 15..11 and function in 10..0. Function 1 writes rs1+rs2 to rd, and function 2 writes rs1-rs2 to rd.
- R4: Function 3 of the register-register format writes 1 to rd when rs1 is less than rs2 compared as signed two's-complement, and writes 0 otherwise.
- R5: LW (opcode 0x23, rs1 in 25..21, rd in 20..16, displacement in 15..0) loads the word at rs1 plus the sign-extended displacement into rd.
- R6: SW (opcode 0x2B) stores the register named in bits 20..16 to rs1 plus the sign-extended displacement. It does this by raising `dmem_we` for exactly one cycle, the fourth cycle of the instruction, with `dmem_addr` and `dmem_wdata` valid in that cycle. `dmem_we` is low at all other times.
- R7: BEQZ (opcode 0x04) sets the next PC to PC+4 plus the sign-extended bits 15..0 when register rs1 is zero, and to PC+4 otherwise.
- R8: The jump (opcode 0x02) sets the next PC to PC+4 plus the sign-extended 26-bit offset in bits 25..0.
- R9: A write to register 0 is discarded, so register 0 always reads as zero.
- R10: HLT (opcode 0x3F) raises `halted` two cycles after its fetch cycle. After that, `halted` stays high, `imem_addr` stays on the halt instruction and `dmem_we` stays low until reset.
- R11: An unused opcode, or a register-register function other than 1, 2 or 3, changes no register and no memory location, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Instruction fetch byte address (current PC) |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Data memory byte address |
| dmem_we | output | 1 | Data write strobe (high = write, low = read) |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |
| halted | output | 1 | High once a halt instruction has been decoded |

## Verification
A wrong PC or a mis-taken branch shows at `imem_addr` in the first cycle of the next instruction, so it is seen within five cycles. A corrupted register, or a result written to the wrong destination, stays hidden until some store copies that register out. For this reason every test program ends by storing each result, and the data memory is compared after halt. A step sequencer that slips, or a misdecoded store, moves or suppresses the single-cycle `dmem_we` pulse, and the cycle-accurate model catches this in the same cycle.

// File: rtl/mc_risc_core.sv
module mc_risc_core #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [XLEN-1:0] imem_addr,
  input  logic [31:0]     imem_data,
  output logic [XLEN-1:0] dmem_addr,
  output logic            dmem_we,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata,
  output logic            halted
);
  localparam logic [5:0] OP_RR  = 6'h00;
  localparam logic [5:0] OP_JMP = 6'h02;
  localparam logic [5:0] OP_BZ  = 6'h04;
  localparam logic [5:0] OP_LW  = 6'h23;
  localparam logic [5:0] OP_SW  = 6'h2B;
  localparam logic [5:0] OP_HLT = 6'h3F;
  localparam logic [10:0] FN_ADD = 11'd1;
  localparam logic [10:0] FN_SUB = 11'd2;
  localparam logic [10:0] FN_SLT = 11'd3;

  typedef enum logic [2:0] {S_FETCH, S_DECODE, S_EXEC, S_MEM, S_WB, S_HALT} step_t;
  step_t step;

  logic [XLEN-1:0] pc, npc, a, b, imm, aluo, lmd, alu;
  logic [31:0]     ir;
  logic            cond;
  logic [XLEN-1:0] rf [32];

  wire [5:0]  op   = ir[31:26];
  wire [10:0] func = ir[10:0];
  wire is_rr  = op == OP_RR;
  wire is_lw  = op == OP_LW;
  wire is_sw  = op == OP_SW;
  wire is_bz  = op == OP_BZ;
  wire is_j   = op == OP_JMP;
  wire is_hlt = op == OP_HLT;
  wire rr_ok  = is_rr && (func == FN_ADD || func == FN_SUB || func == FN_SLT);
  wire [4:0] dest = is_rr ? ir[15:11] : ir[20:16];
  wire wb_en  = (rr_ok || is_lw) && dest != 5'd0;
  wire taken  = is_j || (is_bz && cond);

  always_comb begin
    alu = '0;
    if (is_rr) begin
      case (func)
        FN_ADD:  alu = a + b;
        FN_SUB:  alu = a - b;
        FN_SLT:  alu = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
        default: alu = '0;
      endcase
    end else if (is_lw || is_sw) begin
      alu = a + imm;
    end else if (is_bz || is_j) begin
      alu = npc + imm;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= S_FETCH;
      pc   <= '0;
      npc  <= '0;
      ir   <= '0;
      a    <= '0;
      b    <= '0;
      imm  <= '0;
      aluo <= '0;
      lmd  <= '0;
      cond <= 1'b0;
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else begin
      case (step)
        S_FETCH: begin
          ir   <= imem_data;
          npc  <= pc + XLEN'(4);
          step <= S_DECODE;
        end
        S_DECODE: begin
          a    <= rf[ir[25:21]];
          b    <= rf[ir[20:16]];
          imm  <= is_j ? {{(XLEN-26){ir[25]}}, ir[25:0]} : {{(XLEN-16){ir[15]}}, ir[15:0]};
          step <= is_hlt ? S_HALT : S_EXEC;
        end
        S_EXEC: begin
          aluo <= alu;
          cond <= a == '0;
          step <= S_MEM;
        end
        S_MEM: begin
          if (is_lw) lmd <= dmem_rdata;
          pc   <= taken ? aluo : npc;
          step <= S_WB;
        end
        S_WB: begin
          if (wb_en) rf[dest] <= is_lw ? lmd : aluo;
          step <= S_FETCH;
        end
        default: step <= S_HALT;
      endcase
    end
  end

  assign imem_addr  = pc;
  assign dmem_addr  = aluo;
  assign dmem_wdata = b;
  assign dmem_we    = step == S_MEM && is_sw;
  assign halted     = step == S_HALT;
endmodule

module mc_risc_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] imem_addr,
  input logic            dmem_we,
  input logic            halted
);
  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> (imem_addr == '0 && !halted && !dmem_we)); // R1
  AST_WRITE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) dmem_we |=> !dmem_we); // R6
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted); // R10
  AST_HALT_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n) halted |-> !dmem_we); // R10
  AST_HALT_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) halted |=> $stable(imem_addr)); // R10
endmodule

bind mc_risc_core mc_risc_core_chk #(.XLEN(XLEN)) chk (.*);

// File: tb/mc_risc_core_test.sv
`timescale 1ns/1ps
module mc_risc_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, halted;

  always #2 clk = ~clk;

  mc_risc_core uut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_we(dmem_we), .dmem_wdata(dmem_wdata),
    .dmem_rdata(dmem_rdata), .halted(halted)
  );

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] init_mem [64];
  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) dmem[i] <= init_mem[i];
    end else if (dmem_we) begin
      dmem[dmem_addr[7:2]] <= dmem_wdata;
    end
  end

  int checks = 0;
  int errors = 0;
  logic [31:0] mreg [32];
  logic [31:0] mmem [64];
  logic [31:0] mpc;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rr(input logic [4:0] rd, input logic [4:0] rs1, input logic [4:0] rs2, input logic [10:0] f);
    return {6'h00, rs1, rs2, rd, f};
  endfunction
  function automatic logic [31:0] im(input logic [5:0] op, input logic [4:0] rd, input logic [4:0] rs1, input logic [15:0] v);
    return {op, rs1, rd, v};
  endfunction
  function automatic logic [31:0] jp(input logic [25:0] off);
    return {6'h02, off};
  endfunction

  localparam logic [31:0] HLT = 32'hFC00_0000;

  task automatic clear_prog();
    for (int i = 0; i < 64; i++) begin
      imem[i] = HLT;
      init_mem[i] = 32'h0;
    end
  endtask

  task automatic run_prog(input string name);
    logic [31:0] ins, npc, ea, wd;
    logic [5:0]  op;
    logic [4:0]  rs1, rs2, rdst;
    logic        wr, sw;
    bit          done;
    rst_n = 1'b0;
    mpc = 0;
    for (int i = 0; i < 32; i++) mreg[i] = 0;
    for (int i = 0; i < 64; i++) mmem[i] = init_mem[i];
    repeat (3) @(negedge clk);
    chk("R1", {name, " reset pc"}, imem_addr, 32'h0);
    chk("R1", {name, " reset halted"}, {31'b0, halted}, 32'h0);
    chk("R1", {name, " reset write strobe"}, {31'b0, dmem_we}, 32'h0);
    rst_n = 1'b1;
    done = 0;
    for (int n = 0; n < 400 && !done; n++) begin
      ins = imem[mpc[7:2]];
      chk("R2", {name, " fetch address"}, imem_addr, mpc);
      chk("R10", {name, " halted low while running"}, {31'b0, halted}, 32'h0);
      op = ins[31:26]; rs1 = ins[25:21]; rs2 = ins[20:16];
      if (op == 6'h3F) begin
        @(negedge clk);
        chk("R10", {name, " halted not yet raised"}, {31'b0, halted}, 32'h0);
        repeat (8) begin
          @(negedge clk);
          chk("R10", {name, " halted high"}, {31'b0, halted}, 32'h1);
          chk("R10", {name, " pc frozen"}, imem_addr, mpc);
          chk("R10", {name, " no store after halt"}, {31'b0, dmem_we}, 32'h0);
        end
        done = 1;
      end else begin
        npc = mpc + 4; wr = 0; sw = 0; wd = 0; rdst = rs2; ea = 0;
        case (op)
          6'h00: begin
            rdst = ins[15:11];
            case (ins[10:0])
              11'd1: begin wr = 1; wd = mreg[rs1] + mreg[rs2]; end
              11'd2: begin wr = 1; wd = mreg[rs1] - mreg[rs2]; end
              11'd3: begin wr = 1; wd = ($signed(mreg[rs1]) < $signed(mreg[rs2])) ? 1 : 0; end
              default: ;
            endcase
          end
          6'h23: begin
            ea = mreg[rs1] + {{16{ins[15]}}, ins[15:0]};
            wr = 1; wd = mmem[ea[7:2]];
          end
          6'h2B: begin
            ea = mreg[rs1] + {{16{ins[15]}}, ins[15:0]};
            sw = 1;
          end
          6'h04: if (mreg[rs1] == 0) npc = mpc + 4 + {{16{ins[15]}}, ins[15:0]};
          6'h02: npc = mpc + 4 + {{6{ins[25]}}, ins[25:0]};
          default: ;
        endcase
        for (int p = 0; p < 5; p++) begin
          if (p == 3 && sw) begin
            chk("R6", {name, " store strobe"}, {31'b0, dmem_we}, 32'h1);
            chk("R6", {name, " store address"}, dmem_addr, ea);
            chk("R6", {name, " store data"}, dmem_wdata, mreg[rs2]);
          end else begin
            chk("R6", {name, " strobe idle"}, {31'b0, dmem_we}, 32'h0);
          end
          @(negedge clk);
        end
        if (wr && rdst != 0) mreg[rdst] = wd;
        if (sw) mmem[ea[7:2]] = mreg[rs2];
        mpc = npc;
      end
    end
    chk("R10", {name, " program reached halt"}, {31'b0, done}, 32'h1);
    for (int i = 0; i < 16; i++) chk("R5", {name, " memory matches model"}, dmem[i], mmem[i]);
  endtask

  initial begin
    clear_prog();
    init_mem[1] = 32'd7; init_mem[2] = 32'hFFFF_FFFD; init_mem[3] = 32'd16;
    init_mem[8] = 32'hDEAD_BEEF; init_mem[10] = 32'h5555_5555; init_mem[11] = 32'hAAAA_0000;
    imem[0]  = im(6'h23, 1, 0, 16'd4);
    imem[1]  = im(6'h23, 2, 0, 16'd8);
    imem[2]  = rr(3, 1, 2, 11'd1);
    imem[3]  = rr(4, 1, 2, 11'd2);
    imem[4]  = rr(5, 1, 2, 11'd3);
    imem[5]  = rr(6, 2, 1, 11'd3);
    imem[6]  = rr(0, 1, 1, 11'd1);
    imem[7]  = im(6'h23, 9, 0, 16'd12);
    imem[8]  = im(6'h23, 8, 9, -16'sd8);
    imem[9]  = im(6'h23, 0, 0, 16'd4);
    imem[10] = im(6'h2B, 3, 0, 16'd16);
    imem[11] = im(6'h2B, 4, 0, 16'd20);
    imem[12] = im(6'h2B, 5, 0, 16'd24);
    imem[13] = im(6'h2B, 6, 0, 16'd28);
    imem[14] = im(6'h2B, 0, 0, 16'd32);
    imem[15] = im(6'h2B, 8, 0, 16'd36);
    imem[16] = rr(10, 1, 2, 11'd7);
    imem[17] = im(6'h11, 10, 1, 16'd5);
    imem[18] = im(6'h2B, 10, 0, 16'd40);
    imem[19] = HLT;
    imem[20] = im(6'h2B, 1, 0, 16'd44);
    run_prog("alu");
    chk("R3", "add result", dmem[4], 32'd4);
    chk("R3", "sub result", dmem[5], 32'd10);
    chk("R4", "signed slt false", dmem[6], 32'd0);
    chk("R4", "signed slt true", dmem[7], 32'd1);
    chk("R9", "register zero stays zero", dmem[8], 32'd0);
    chk("R5", "negative displacement load", dmem[9], 32'hFFFF_FFFD);
    chk("R11", "unused codes leave register", dmem[10], 32'd0);
    chk("R10", "store after halt not done", dmem[11], 32'hAAAA_0000);

    clear_prog();
    init_mem[1] = 32'd36; init_mem[2] = 32'd24;
    imem[0]  = im(6'h23, 1, 0, 16'd4);
    imem[1]  = im(6'h23, 2, 0, 16'd8);
    imem[2]  = rr(3, 1, 2, 11'd2);
    imem[3]  = im(6'h04, 0, 3, 16'd24);
    imem[4]  = rr(4, 1, 2, 11'd3);
    imem[5]  = im(6'h04, 0, 4, 16'd8);
    imem[6]  = rr(2, 2, 1, 11'd2);
    imem[7]  = jp(-26'sd24);
    imem[8]  = rr(1, 1, 2, 11'd2);
    imem[9]  = jp(-26'sd32);
    imem[10] = im(6'h2B, 1, 0, 16'd40);
    run_prog("gcd");
    chk("R7", "gcd through branches", dmem[10], 32'd12);
    chk("R8", "gcd through backward jumps", dmem[10], 32'd12);

    clear_prog();
    init_mem[1] = 32'd99;
    imem[0] = im(6'h23, 1, 0, 16'd4);
    imem[1] = jp(26'd4);
    imem[2] = im(6'h2B, 1, 0, 16'd8);
    imem[3] = im(6'h04, 0, 1, 16'd8);
    imem[4] = im(6'h2B, 1, 0, 16'd12);
    run_prog("skip");
    chk("R8", "forward jump skipped store", dmem[2], 32'd0);
    chk("R7", "branch not taken on nonzero", dmem[3], 32'd99);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 50000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule